// File: doc/BRIEF.md
# Power-Down and Output-Enable Controller

This block decides whether a video receiver core stays powered and which of its output groups are driven. Three sources can ask for power-down: an external pin, a register bit and an automatic request raised when every sync input has gone quiet. The pin is read through a polarity bit. A 2-bit function code then sets two things on its own terms: whether the core loses power, and whether the sliced-sync output stays driven.

The block drives four registered enables. One is the core power enable. One covers the main output group: horizontal sync, vertical sync, data clock and the 30 data bits. One covers the sliced-sync output, and one covers the audio serial pins. Each sync input has a watchdog built from a counter of reference clocks. The watchdog flags the input as absent once no level change has been seen for a programmable number of cycles. The automatic request clears on the first edge that is detected.

Top module: `pwr_oe_ctrl`

## Requirements
- R1: While rst_ni is low, all four enable outputs are 0.
- R2: The pin counts as active when its synchronized level equals pd_pol_i (0 = active low, 1 = active high). While the pin is inactive and no other request is present, all four enables are 1.
- R3: The pin passes through two flip-flops before it is decoded. A pin change shows at the enables on the third rising edge after it. Changes on the register-style inputs show on the first rising edge.
- R4: While the pin is active, the main enable is 0. If pd_func_i[1] is 0, the core power enable is 0. If pd_func_i[0] is 1, the sliced-sync enable is 0. The codes are 00 = power off with sliced sync kept, 01 = power off with all outputs off, 10 = power on with sliced sync kept, 11 = power on with all outputs off.
- R5: pd_reg_i = 1 forces the core power enable, the main enable and the audio enable to 0. It leaves the sliced-sync enable unaffected.
- R6: A sync input is absent once its cycle counter reaches timeout_i. An edge is any level change seen after two synchronizing flip-flops, and an edge clears that counter.
- R7: With auto_pd_en_i = 1 and every sync input absent, the core power enable, the main enable and the audio enable go to 0, and the sliced-sync enable is left alone. A single detected edge on any input ends the request, and the enables recover on the fourth rising edge after the input changes.
- R8: The audio enable is 0 when audio_tri_i is 1, and also whenever the main enable is 0.
- R9: The core is powered only when none of the three requests is present: the pin request, the register request and the automatic request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_pin_i | input | 1 | External power-down pin, asynchronous |
| pd_pol_i | input | 1 | Pin polarity: 1 means active high |
| pd_func_i | input | 2 | Pin function code |
| pd_reg_i | input | 1 | Register power-down request |
| auto_pd_en_i | input | 1 | Enables automatic power-down when sync is lost |
| audio_tri_i | input | 1 | Puts the audio serial pins in high impedance |
| sync_i | input | NUM_SYNC | Sync inputs, asynchronous |
| timeout_i | input | CNT_W | Absence timeout in reference clocks |
| core_pwr_en_o | output | 1 | Core power enable |
| main_oe_o | output | 1 | Enable for sync, clock and data outputs |
| sync_out_oe_o | output | 1 | Enable for the sliced-sync output |
| audio_oe_o | output | 1 | Enable for the audio serial outputs |

## Verification
The bench targets the pin's three-edge latency. A design missing a synchronizer stage would drop the main enable one cycle early. The bench also steers every function code through the pin while the register and automatic requests are toggled, so a decoder with swapped code bits, or one that lets the register bit turn off the sliced-sync output, would show up at the enables. The sync watchdog is run against timeouts across a wide range and against idle, partial and full activity. A counter that does not clear on edges, that requires only one input to be absent, or that fails to saturate would release or assert the automatic request on the wrong cycle.

// File: rtl/pwr_oe_pkg.sv
package pwr_oe_pkg;

  typedef enum logic [1:0] {
    PF_OFF_KEEP_SO = 2'b00,
    PF_OFF_ALL     = 2'b01,
    PF_ON_KEEP_SO  = 2'b10,
    PF_ON_ALL      = 2'b11
  } pin_func_e;

  typedef struct packed {
    logic core_pwr_en;
    logic main_oe;
    logic sync_out_oe;
    logic audio_oe;
  } oe_t;

  localparam oe_t OE_RESET = '0;

endpackage

// File: rtl/pd_sync2.sv
module pd_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sync_watchdog.sv
module sync_watchdog #(
  parameter int NUM_SYNC = 3,
  parameter int CNT_W    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SYNC-1:0] sync_s_i,
  input  logic [CNT_W-1:0]    timeout_i,
  output logic                all_absent_o
);
  logic [NUM_SYNC-1:0] prev_q;
  logic [NUM_SYNC-1:0] edge_w;
  logic [NUM_SYNC-1:0] absent_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_s_i;
  end

  assign edge_w = sync_s_i ^ prev_q;

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_ch
    logic [CNT_W-1:0] cnt_q;

    assign absent_w[g] = (cnt_q >= timeout_i);

    // saturates at the timeout; any edge restarts the window
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (edge_w[g])    cnt_q <= '0;
      else if (!absent_w[g]) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign all_absent_o = &absent_w;
endmodule

// File: rtl/pd_decode.sv
module pd_decode
  import pwr_oe_pkg::*;
(
  input  logic       pin_act_i,
  input  logic [1:0] pd_func_i,
  input  logic       pd_reg_i,
  input  logic       auto_req_i,
  input  logic       audio_tri_i,
  output oe_t        oe_o
);
  logic pin_core_off, pin_so_off;

  always_comb begin
    pin_core_off = 1'b0;
    pin_so_off   = 1'b0;
    if (pin_act_i) begin
      unique case (pin_func_e'(pd_func_i))
        PF_OFF_KEEP_SO: pin_core_off = 1'b1;
        PF_OFF_ALL:     begin pin_core_off = 1'b1; pin_so_off = 1'b1; end
        PF_ON_KEEP_SO:  ;
        PF_ON_ALL:      pin_so_off = 1'b1;
        default:        ;
      endcase
    end
  end

  always_comb begin
    oe_o.core_pwr_en = !(pin_core_off || pd_reg_i || auto_req_i);
    oe_o.main_oe     = !(pin_act_i || pd_reg_i || auto_req_i);
    oe_o.sync_out_oe = !pin_so_off;
    oe_o.audio_oe    = oe_o.main_oe && !audio_tri_i;
  end
endmodule

// File: rtl/pwr_oe_ctrl.sv
module pwr_oe_ctrl
  import pwr_oe_pkg::*;
#(
  parameter int NUM_SYNC = 3,
  parameter int CNT_W    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pd_pin_i,
  input  logic                pd_pol_i,
  input  logic [1:0]          pd_func_i,
  input  logic                pd_reg_i,
  input  logic                auto_pd_en_i,
  input  logic                audio_tri_i,
  input  logic [NUM_SYNC-1:0] sync_i,
  input  logic [CNT_W-1:0]    timeout_i,
  output logic                core_pwr_en_o,
  output logic                main_oe_o,
  output logic                sync_out_oe_o,
  output logic                audio_oe_o
);
  logic                pin_s;
  logic                pin_act;
  logic [NUM_SYNC-1:0] sync_s;
  logic                all_absent;
  logic                auto_req;
  oe_t                 oe_d, oe_q;

  pd_sync2 #(.W(1)) u_pin_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pd_pin_i), .q_o(pin_s)
  );

  pd_sync2 #(.W(NUM_SYNC)) u_vs_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(sync_i), .q_o(sync_s)
  );

  sync_watchdog #(.NUM_SYNC(NUM_SYNC), .CNT_W(CNT_W)) u_wdog (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_s_i    (sync_s),
    .timeout_i   (timeout_i),
    .all_absent_o(all_absent)
  );

  assign pin_act  = (pin_s == pd_pol_i);
  assign auto_req = auto_pd_en_i && all_absent;

  pd_decode u_dec (
    .pin_act_i  (pin_act),
    .pd_func_i  (pd_func_i),
    .pd_reg_i   (pd_reg_i),
    .auto_req_i (auto_req),
    .audio_tri_i(audio_tri_i),
    .oe_o       (oe_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= OE_RESET;
    else         oe_q <= oe_d;
  end

  assign core_pwr_en_o = oe_q.core_pwr_en;
  assign main_oe_o     = oe_q.main_oe;
  assign sync_out_oe_o = oe_q.sync_out_oe;
  assign audio_oe_o    = oe_q.audio_oe;
endmodule

// File: rtl/pwr_oe_ctrl_chk.sv
module pwr_oe_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pin_act_i,
  input logic [1:0] pd_func_i,
  input logic       pd_reg_i,
  input logic       auto_pd_en_i,
  input logic       audio_tri_i,
  input logic       core_pwr_en_o,
  input logic       main_oe_o,
  input logic       sync_out_oe_o,
  input logic       audio_oe_o
);
  assert_main_needs_core_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_oe_o |-> core_pwr_en_o);

  assert_audio_under_main_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    audio_oe_o |-> main_oe_o);

  assert_reg_pd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_reg_i |=> (!core_pwr_en_o && !main_oe_o && !audio_oe_o));

  assert_pin_so_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_act_i && pd_func_i[0]) |=> !sync_out_oe_o);

  assert_pin_so_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pin_act_i || !pd_func_i[0]) |=> sync_out_oe_o);

  assert_idle_all_on_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pin_act_i && !pd_reg_i && !auto_pd_en_i && !audio_tri_i)
      |=> (core_pwr_en_o && main_oe_o && sync_out_oe_o && audio_oe_o));
endmodule

bind pwr_oe_ctrl pwr_oe_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pin_act_i    (pin_act),
  .pd_func_i    (pd_func_i),
  .pd_reg_i     (pd_reg_i),
  .auto_pd_en_i (auto_pd_en_i),
  .audio_tri_i  (audio_tri_i),
  .core_pwr_en_o(core_pwr_en_o),
  .main_oe_o    (main_oe_o),
  .sync_out_oe_o(sync_out_oe_o),
  .audio_oe_o   (audio_oe_o)
);

// File: tb/pwr_oe_ctrl_bench.sv
module pwr_oe_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 3;
  localparam int CW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          pd_pin_i = 1'b0;
  logic          pd_pol_i = 1'b1;
  logic [1:0]    pd_func_i = 2'b00;
  logic          pd_reg_i = 1'b0;
  logic          auto_pd_en_i = 1'b0;
  logic          audio_tri_i = 1'b0;
  logic [NS-1:0] sync_i = '0;
  logic [CW-1:0] timeout_i = 16'd8;
  logic core_pwr_en_o, main_oe_o, sync_out_oe_o, audio_oe_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string phase_tag = "";

  // bench-side model state
  bit m_pin1, m_pin2;
  bit m_s1 [NS];
  bit m_s2 [NS];
  bit m_prev [NS];
  int m_cnt [NS];
  bit e_core, e_main, e_so, e_aud;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwr_oe_ctrl #(.NUM_SYNC(NS), .CNT_W(CW)) u_pwr_oe_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .pd_pin_i(pd_pin_i), .pd_pol_i(pd_pol_i),
    .pd_func_i(pd_func_i), .pd_reg_i(pd_reg_i), .auto_pd_en_i(auto_pd_en_i),
    .audio_tri_i(audio_tri_i), .sync_i(sync_i), .timeout_i(timeout_i),
    .core_pwr_en_o(core_pwr_en_o), .main_oe_o(main_oe_o),
    .sync_out_oe_o(sync_out_oe_o), .audio_oe_o(audio_oe_o)
  );

  task automatic chk(string tag, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string tg(string dflt);
    return (phase_tag != "") ? phase_tag : dflt;
  endfunction

  // advance one clock and check every enable against the requirement model
  task automatic step();
    bit pa, all_abs, auto_r, edg;
    @(negedge clk_i);
    pa = (m_pin2 == pd_pol_i);
    all_abs = 1;
    for (int i = 0; i < NS; i++) if (m_cnt[i] < int'(timeout_i)) all_abs = 0;
    auto_r = auto_pd_en_i && all_abs;
    e_core = !((pa && !pd_func_i[1]) || pd_reg_i || auto_r);
    e_main = !(pa || pd_reg_i || auto_r);
    e_so   = !(pa && pd_func_i[0]);
    e_aud  = e_main && !audio_tri_i;
    for (int i = 0; i < NS; i++) begin
      edg = m_s2[i] ^ m_prev[i];
      if (edg) m_cnt[i] = 0;
      else if (m_cnt[i] < int'(timeout_i)) m_cnt[i]++;
      m_prev[i] = m_s2[i];
      m_s2[i] = m_s1[i];
      m_s1[i] = sync_i[i];
    end
    m_pin2 = m_pin1;
    m_pin1 = pd_pin_i;
    chk(tg("R9"), "core_pwr_en", core_pwr_en_o, e_core);
    chk(tg("R4"), "main_oe", main_oe_o, e_main);
    chk(tg("R4"), "sync_out_oe", sync_out_oe_o, e_so);
    chk(tg("R8"), "audio_oe", audio_oe_o, e_aud);
  endtask

  task automatic set_cfg(bit pol, bit [1:0] fn, bit rg, bit ae, bit at, int to);
    pd_pol_i = pol; pd_func_i = fn; pd_reg_i = rg;
    auto_pd_en_i = ae; audio_tri_i = at; timeout_i = CW'(to);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [NS-1:0] mask;
    bit pin_moves;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NS; i++) begin
      m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0; m_cnt[i] = 0;
    end
    m_pin1 = 0; m_pin2 = 0;

    // R1: reset state
    repeat (3) begin
      @(negedge clk_i);
      chk("R1", "core_pwr_en", core_pwr_en_o, 1'b0);
      chk("R1", "main_oe", main_oe_o, 1'b0);
      chk("R1", "sync_out_oe", sync_out_oe_o, 1'b0);
      chk("R1", "audio_oe", audio_oe_o, 1'b0);
    end
    set_cfg(1, 2'b00, 0, 0, 0, 8);
    pd_pin_i = 0;
    rst_ni = 1'b1;

    // R2: idle, pin inactive (active-high polarity, pin low)
    phase_tag = "R2";
    repeat (6) step();
    chk("R2", "idle core_pwr_en", core_pwr_en_o, 1'b1);
    chk("R2", "idle sync_out_oe", sync_out_oe_o, 1'b1);
    // R2: active-low polarity makes a low pin active
    pd_pol_i = 0; pd_func_i = 2'b10;
    step();
    chk("R2", "pol0 main_oe", main_oe_o, 1'b0);
    pd_pol_i = 1;
    repeat (3) step();

    // R3: pin latency, three edges
    phase_tag = "R3";
    pd_func_i = 2'b11;
    pd_pin_i = 1;
    step(); chk("R3", "main_oe edge1", main_oe_o, 1'b1);
    step(); chk("R3", "main_oe edge2", main_oe_o, 1'b1);
    step(); chk("R3", "main_oe edge3", main_oe_o, 1'b0);
    chk("R3", "sync_out_oe edge3", sync_out_oe_o, 1'b0);
    // register input latency: one edge
    pd_func_i = 2'b10;
    step(); chk("R3", "sync_out_oe func", sync_out_oe_o, 1'b1);

    // R4: every function code
    phase_tag = "R4";
    for (int f = 0; f < 4; f++) begin
      pd_func_i = 2'(f);
      step();
      chk("R4", "core code", core_pwr_en_o, f[1]);
      chk("R4", "so code", sync_out_oe_o, !f[0]);
    end
    pd_pin_i = 0;
    repeat (4) step();

    // R5: register power-down keeps sliced sync driven
    phase_tag = "R5";
    pd_reg_i = 1;
    step();
    chk("R5", "core", core_pwr_en_o, 1'b0);
    chk("R5", "sync_out_oe", sync_out_oe_o, 1'b1);
    pd_reg_i = 0;
    step();

    // R6/R7: sync loss and release
    phase_tag = "R6";
    set_cfg(1, 2'b00, 0, 1, 0, 8);
    repeat (12) step();
    chk("R6", "auto core off", core_pwr_en_o, 1'b0);
    chk("R7", "auto so kept", sync_out_oe_o, 1'b1);
    phase_tag = "R7";
    sync_i[1] = 1;
    step(); step(); step();
    chk("R7", "core edge3", core_pwr_en_o, 1'b0);
    step();
    chk("R7", "core edge4", core_pwr_en_o, 1'b1);
    repeat (12) step();
    chk("R6", "re-absent", core_pwr_en_o, 1'b0);

    // R8: audio tri-state
    phase_tag = "R8";
    set_cfg(1, 2'b00, 0, 0, 1, 8);
    step();
    chk("R8", "audio off", audio_oe_o, 1'b0);
    chk("R8", "main on", main_oe_o, 1'b1);
    phase_tag = "";

    // random segments
    for (int s = 0; s < 60; s++) begin
      set_cfg($urandom % 2, 2'($urandom % 4), ($urandom % 4) == 0,
              $urandom % 2, ($urandom % 3) == 0, 4 + $urandom % 30);
      case ($urandom % 3)
        0: mask = '0;
        1: mask = NS'($urandom);
        default: mask = '1;
      endcase
      pin_moves = $urandom % 2;
      for (int c = 0; c < 250; c++) begin
        step();
        for (int i = 0; i < NS; i++)
          if (mask[i] && ($urandom % 5 == 0)) sync_i[i] = ~sync_i[i];
        if (pin_moves && ($urandom % 20 == 0)) pd_pin_i = ~pd_pin_i;
        if ($urandom % 100 == 0) pd_func_i = 2'($urandom % 4);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule